// File: doc/BRIEF.md
# Current-Vector Open-Switch Fault Detector

This block watches a stream of normalised three-phase input current samples from a bridgeless boost rectifier. Each sample is projected onto a two-axis stationary frame. The length of the resulting current vector is then compared with its own average over an earlier power cycle. When one power switch opens, the current path for one half-cycle disappears. The vector then leaves its circular locus and its length drops sharply for part of each cycle. Ordinary load steps and supply disturbances keep the vector near the circle.

The absolute difference between the length and the reference is summed over a short programmable window of samples. When a window's sum exceeds a threshold plus a margin, a sticky fault flag is raised. The flag stays set until the controller acknowledges it. The alpha and beta components of every sample leave the block on an output stream for downstream use, for example to locate the faulty switch.

Both streams use valid/ready. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. The block holds one output sample. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input one-for-one. While `out_valid` is high and `out_ready` is low, the output data does not change.

Top module: `cvec_fault_det`

## Requirements
- R1: For an accepted sample (ia, ib, ic), each a signed 16-bit value, the block produces two signed 17-bit outputs, rounded toward minus infinity. `out_alpha` = (13377·ia − 6689·ib − 6689·ic) >>> 14 and `out_beta` = (11585·(ib − ic)) >>> 14. These appear on the clock edge that accepts the sample.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. `out_valid` rises on the edge after a transfer in. It falls after an edge where it was high with `out_ready` high and no new sample arrived. While `out_valid` is high and `out_ready` is low, `out_alpha` and `out_beta` hold their values.
- R3: The vector length of a sample is estimated as L = M + (m >> 2) + (m >> 3). Here M is the larger and m the smaller of |alpha| and |beta|.
- R4: For the n-th accepted sample (counting from 0 after reset), the cycle sum Z is the sum of L(k) over the cycle-length (C = 200 by default) samples with n−2C < k ≤ n−C. The deviation of that sample is |Z − C·L(n)|, which is C times |L0 − L| where L0 = Z/C.
- R5: Samples with n < 2C contribute nothing to detection. The fault flag cannot be set before 2C + 1 samples have been accepted.
- R6: Deviations of samples with n ≥ 2C are summed in a window that closes on the `win_len`-th such sample, or on every such sample when `win_len` is 0. The window is evaluated when it closes and then restarts from zero.
- R7: When a window closes, the flag is set if its sum exceeds C·(`thr` + `res`). Equivalently, the sum of |L0 − L| exceeds `thr` + `res` in length units. `thr` and `res` are unsigned and are read in the cycle of evaluation.
- R8: `fault` stays high until an edge with `fault_ack` high clears it. A detection on the same edge wins over the acknowledge. `fault_ack` has no other effect.
- R9: After reset, `out_valid` and `fault` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_ia | input | 16 | Phase A current, signed |
| in_ib | input | 16 | Phase B current, signed |
| in_ic | input | 16 | Phase C current, signed |
| out_valid | output | 1 | Frame sample valid |
| out_ready | input | 1 | Downstream can take a sample |
| out_alpha | output | 17 | Alpha component, signed |
| out_beta | output | 17 | Beta component, signed |
| win_len | input | 7 | Samples per detection window (0 means 1) |
| thr | input | 16 | Detection reference in length units |
| res | input | 16 | Residual margin in length units |
| fault_ack | input | 1 | Clears the fault flag |
| fault | output | 1 | Sticky open-switch fault flag |

## Verification
The assertions assume that reset lasts at least one edge and that every input is a known level on each rising edge. They also assume that `in_valid` is never raised for a sample that the data inputs do not yet carry. No assumption is made on how `out_ready` or `fault_ack` behave, so the bench toggles them freely, at random or in directed pulses. The bench keeps all currents within the signed 16-bit range, including both extremes. It holds `win_len`, `thr` and `res` steady except at the points where it changes them on purpose.

// File: rtl/cvf_pkg.sv
package cvf_pkg;
  // fractional bits of the frame transform coefficients
  localparam int COEF_FB = 14;
  // sqrt(2/3), 1/sqrt(6), 1/sqrt(2) scaled by 2^COEF_FB
  localparam int K_MAIN  = 13377;
  localparam int K_SIDE  = 6689;
  localparam int K_DIAG  = 11585;
endpackage

// File: rtl/cvf_frame.sv
module cvf_frame #(
  parameter int IW = 16,
  parameter int AW = IW + 1
) (
  input  logic signed [IW-1:0] ia,
  input  logic signed [IW-1:0] ib,
  input  logic signed [IW-1:0] ic,
  output logic signed [AW-1:0] alpha,
  output logic signed [AW-1:0] beta
);
  import cvf_pkg::*;

  localparam int PW = IW + 17;
  localparam logic signed [PW-1:0] KM = PW'(K_MAIN);
  localparam logic signed [PW-1:0] KS = PW'(K_SIDE);
  localparam logic signed [PW-1:0] KD = PW'(K_DIAG);

  logic signed [PW-1:0] xa, xb, xc;
  logic signed [PW-1:0] pa, pb;

  always_comb begin
    xa = PW'(ia);
    xb = PW'(ib);
    xc = PW'(ic);
    pa = KM * xa - KS * xb - KS * xc;
    pb = KD * (xb - xc);
    alpha = AW'(pa >>> COEF_FB);
    beta  = AW'(pb >>> COEF_FB);
  end
endmodule

// File: rtl/cvf_mag.sv
module cvf_mag #(
  parameter int AW = 17,
  parameter int RW = AW + 1
) (
  input  logic signed [AW-1:0] alpha,
  input  logic signed [AW-1:0] beta,
  output logic        [RW-1:0] len
);
  logic [AW-1:0] ax, bx, big, sml;

  always_comb begin
    ax  = alpha[AW-1] ? AW'(-alpha) : AW'(alpha);
    bx  = beta[AW-1]  ? AW'(-beta)  : AW'(beta);
    big = (ax >= bx) ? ax : bx;
    sml = (ax >= bx) ? bx : ax;
    len = RW'(big) + RW'(sml >> 2) + RW'(sml >> 3);
  end
endmodule

// File: rtl/cvf_ref.sv
module cvf_ref #(
  parameter int RW  = 18,
  parameter int CYC = 200,
  parameter int CSW = RW + $clog2(CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [RW-1:0]  len,
  output logic [CSW-1:0] dev,
  output logic           armed
);
  localparam int DEPTH = 2 * CYC;
  localparam int PTW   = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [PTW-1:0] P_HALF = PTW'(CYC);
  localparam logic [PTW-1:0] P_LAST = PTW'(DEPTH - 1);
  localparam logic [CW-1:0]  N_ONE  = CW'(CYC);
  localparam logic [CW-1:0]  N_TWO  = CW'(DEPTH);
  localparam logic [CSW-1:0] K_CYC  = CSW'(CYC);

  logic [RW-1:0]  hist [DEPTH];
  logic [PTW-1:0] wp, tp;
  logic [CW-1:0]  seen;
  logic [CSW-1:0] zsum, zsum_nx, scaled;
  logic [RW-1:0]  tap_one, tap_two;

  always_comb begin
    tp      = (wp >= P_HALF) ? wp - P_HALF : wp + P_HALF;
    tap_one = hist[tp];
    tap_two = hist[wp];
    zsum_nx = zsum
            + ((seen >= N_ONE) ? CSW'(tap_one) : '0)
            - ((seen >= N_TWO) ? CSW'(tap_two) : '0);
    scaled  = K_CYC * CSW'(len);
    dev     = (zsum_nx >= scaled) ? zsum_nx - scaled : scaled - zsum_nx;
    armed   = (seen == N_TWO);
  end

  always_ff @(posedge clk) begin
    if (en) hist[wp] <= len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      seen <= '0;
      zsum <= '0;
    end else if (en) begin
      wp   <= (wp == P_LAST) ? '0 : wp + 1'b1;
      if (seen != N_TWO) seen <= seen + 1'b1;
      zsum <= zsum_nx;
    end
  end
endmodule

// File: rtl/cvf_win.sv
module cvf_win #(
  parameter int CSW = 26,
  parameter int WLW = 7,
  parameter int TW  = 16,
  parameter int CYC = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           armed,
  input  logic [CSW-1:0] dev,
  input  logic [WLW-1:0] win_len,
  input  logic [TW-1:0]  thr,
  input  logic [TW-1:0]  res,
  input  logic           ack,
  output logic           fault
);
  localparam int SW = CSW + WLW;
  localparam int LW = TW + 1 + $clog2(CYC + 1);
  localparam int XW = (SW > LW) ? SW : LW;

  logic [SW-1:0]  acc, acc_nx;
  logic [WLW-1:0] cnt;
  logic [WLW:0]   cnt_nx;
  logic [LW-1:0]  lim;
  logic           step, close, hit;

  always_comb begin
    step   = en && armed;
    acc_nx = acc + SW'(dev);
    cnt_nx = {1'b0, cnt} + 1'b1;
    close  = cnt_nx >= {1'b0, win_len};
    lim    = LW'(CYC) * (LW'(thr) + LW'(res));
    hit    = step && close && (XW'(acc_nx) > XW'(lim));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      if (step) begin
        acc <= close ? '0 : acc_nx;
        cnt <= close ? '0 : cnt_nx[WLW-1:0];
      end
      if (hit)      fault <= 1'b1;
      else if (ack) fault <= 1'b0;
    end
  end
endmodule

// File: rtl/cvec_fault_det.sv
module cvec_fault_det #(
  parameter  int IW  = 16,
  parameter  int CYC = 200,
  parameter  int WLW = 7,
  parameter  int TW  = 16,
  localparam int AW  = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [IW-1:0] in_ia,
  input  logic signed [IW-1:0] in_ib,
  input  logic signed [IW-1:0] in_ic,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [AW-1:0] out_alpha,
  output logic signed [AW-1:0] out_beta,
  input  logic [WLW-1:0]       win_len,
  input  logic [TW-1:0]        thr,
  input  logic [TW-1:0]        res,
  input  logic                 fault_ack,
  output logic                 fault
);
  localparam int RW  = AW + 1;
  localparam int CSW = RW + $clog2(CYC + 1);

  logic signed [AW-1:0] f_alpha, f_beta;
  logic [RW-1:0]        f_len;
  logic [CSW-1:0]       f_dev;
  logic                 f_armed;
  logic                 take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  cvf_frame #(.IW(IW), .AW(AW)) u_frame (
    .ia(in_ia), .ib(in_ib), .ic(in_ic),
    .alpha(f_alpha), .beta(f_beta)
  );

  cvf_mag #(.AW(AW), .RW(RW)) u_mag (
    .alpha(f_alpha), .beta(f_beta), .len(f_len)
  );

  cvf_ref #(.RW(RW), .CYC(CYC), .CSW(CSW)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(take),
    .len(f_len), .dev(f_dev), .armed(f_armed)
  );

  cvf_win #(.CSW(CSW), .WLW(WLW), .TW(TW), .CYC(CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .en(take), .armed(f_armed), .dev(f_dev),
    .win_len(win_len), .thr(thr), .res(res), .ack(fault_ack),
    .fault(fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_alpha <= '0;
      out_beta  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_alpha <= f_alpha;
      out_beta  <= f_beta;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cvf_chk.sv
module cvf_chk #(
  parameter int IW  = 16,
  parameter int CYC = 200,
  parameter int AW  = IW + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [AW-1:0] out_alpha,
  input logic signed [AW-1:0] out_beta,
  input logic                 fault_ack,
  input logic                 fault
);
  localparam int NW = $clog2(2 * CYC + 2);
  localparam logic [NW-1:0] N_ARM = NW'(2 * CYC);
  localparam logic [NW-1:0] N_TOP = NW'(2 * CYC + 1);

  logic [NW-1:0] taken;

  always_ff @(posedge clk) begin
    if (!rst_n) taken <= '0;
    else if (in_valid && in_ready && taken != N_TOP) taken <= taken + 1'b1;
  end

  // R2
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_alpha) && $stable(out_beta)));

  // R2
  valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R5
  quiet_before_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken <= N_ARM) |-> !fault);

  // R7
  rise_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(in_valid && in_ready));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_ack) |=> fault);
endmodule

bind cvec_fault_det cvf_chk #(.IW(IW), .CYC(CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_alpha(out_alpha), .out_beta(out_beta),
  .fault_ack(fault_ack), .fault(fault)
);

// File: tb/test_cvec_fault_det.sv
`timescale 1ns/1ps
module test_cvec_fault_det;
  localparam int C = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, fault_ack, fault;
  logic signed [15:0] in_ia, in_ib, in_ic;
  logic signed [16:0] out_alpha, out_beta;
  logic [6:0]  win_len;
  logic [15:0] thr, res;

  always #4 clk = ~clk;

  cvec_fault_det i_cvec_fault_det (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ia(in_ia), .in_ib(in_ib), .in_ic(in_ic),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_alpha(out_alpha), .out_beta(out_beta),
    .win_len(win_len), .thr(thr), .res(res),
    .fault_ack(fault_ack), .fault(fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  longint rh [0:4095];
  int     n;
  bit     m_ov, m_fault;
  longint m_al, m_be, wsum;
  int     wcnt;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint f_alpha(input longint a, b, c);
    return (13377 * a - 6689 * b - 6689 * c) >>> 14;
  endfunction

  function automatic longint f_beta(input longint b, c);
    return (11585 * (b - c)) >>> 14;
  endfunction

  function automatic longint f_len(input longint al, be);
    longint x, y, mx, mn;
    x = (al < 0) ? -al : al;
    y = (be < 0) ? -be : be;
    mx = (x >= y) ? x : y;
    mn = (x >= y) ? y : x;
    return mx + (mn >> 2) + (mn >> 3);
  endfunction

  // one accepted sample through the model; returns detection hit
  function automatic bit model_take(input longint a, b, c);
    longint z, d, l;
    bit hit;
    hit  = 0;
    m_al = f_alpha(a, b, c);
    m_be = f_beta(b, c);
    l    = f_len(m_al, m_be);
    rh[n] = l;
    z = 0;
    for (int k = n - 2 * C + 1; k <= n - C; k++)
      if (k >= 0) z += rh[k];
    d = z - C * l;
    if (d < 0) d = -d;
    if (n >= 2 * C) begin
      int wl;
      wl = (win_len == 0) ? 1 : int'(win_len);
      wsum += d;
      wcnt++;
      if (wcnt >= wl) begin
        hit  = (wsum > longint'(C) * (longint'(thr) + longint'(res)));
        wsum = 0;
        wcnt = 0;
      end
    end
    n++;
    return hit;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; fault_ack = 1'b0;
    in_ia = '0; in_ib = '0; in_ic = '0;
    n = 0; m_ov = 0; m_fault = 0; wsum = 0; wcnt = 0; m_al = 0; m_be = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(fault == 1'b0, "R9 fault", fault, 0);
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
  endtask

  // called at a negedge; returns at the following negedge
  task automatic cycle(input bit v, input int a, b, c, input bit ordy, input bit ack);
    bit exp_rdy, acc, hit;
    string tag;
    in_valid = v; in_ia = 16'(a); in_ib = 16'(b); in_ic = 16'(c);
    out_ready = ordy; fault_ack = ack;
    #1;
    exp_rdy = !m_ov || ordy;
    chk(in_ready == exp_rdy, "R2 in_ready", in_ready, exp_rdy);
    acc = v && exp_rdy;
    hit = 0;
    @(posedge clk);
    if (acc) begin
      hit  = model_take(a, b, c);
      m_ov = 1;
    end else if (m_ov && ordy) m_ov = 0;
    if (hit) m_fault = 1;
    else if (ack) m_fault = 0;
    @(negedge clk);
    chk(out_valid == m_ov, "R2 out_valid", out_valid, m_ov);
    if (m_ov) begin
      chk(longint'(out_alpha) == m_al, "R1 alpha", out_alpha, m_al);
      chk(longint'(out_beta) == m_be, "R1 beta", out_beta, m_be);
    end
    if (ack)               tag = "R8 fault";
    else if (n <= 2 * C)   tag = "R5 fault";
    else                   tag = "R7 fault (R3 R4 R6)";
    chk(fault == m_fault, tag, fault, m_fault);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic sine_run(input int cnt, input real amp, input int mode, input int p_ordy, input int p_ack);
    for (int i = 0; i < cnt; i++) begin
      real th;
      int a, b, c;
      th = 2.0 * 3.14159265358979 * real'(n % C) / real'(C);
      a = $rtoi(amp * $cos(th)) + int'($urandom_range(0, 16)) - 8;
      b = $rtoi(amp * $cos(th - 2.0943951)) + int'($urandom_range(0, 16)) - 8;
      c = $rtoi(amp * $cos(th + 2.0943951)) + int'($urandom_range(0, 16)) - 8;
      if (mode == 1 && a > 0) a = 0;   // lost positive path on phase A
      if (mode == 2) begin a = 3; b = -2; c = 1; end  // collapsed currents
      cycle(1'b1, a, b, c, ($urandom_range(0, 99) < p_ordy),
            ($urandom_range(0, 99) < p_ack));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    win_len = 7'd0; thr = 16'd0; res = 16'd0;
    @(negedge clk);

    // phase 1: transform extremes, stalls, one-sample windows, zero threshold
    do_reset();
    cycle(1, 0, 0, 0, 1, 0);
    cycle(1, 32767, -32768, 0, 0, 0);
    cycle(1, -32768, 32767, 32767, 0, 0);   // stalled: R2 hold
    cycle(0, 0, 0, 0, 0, 0);
    cycle(1, -32768, 32767, 32767, 1, 0);
    cycle(1, 4096, -2048, -2048, 1, 0);
    cycle(1, 32767, 32767, 32767, 1, 0);
    cycle(1, -32768, -32768, -32768, 1, 0);
    cycle(1, 0, -32768, 32767, 1, 0);
    cycle(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 700; i++)
      cycle($urandom_range(0, 99) < 85, rnd16(), rnd16(), rnd16(),
            $urandom_range(0, 99) < 75, $urandom_range(0, 99) < 5);

    // phase 2: healthy rotation, then collapse, acknowledge, threshold raise
    do_reset();
    win_len = 7'd20; thr = 16'd8000; res = 16'd2000;
    sine_run(1000, 4096.0, 0, 90, 0);
    sine_run(80, 4096.0, 2, 100, 0);
    cycle(0, 0, 0, 0, 1, 1);                // R8 clear
    cycle(0, 0, 0, 0, 1, 0);
    sine_run(60, 4096.0, 2, 100, 0);        // detection again
    thr = 16'hFFFF; res = 16'hFFFF;
    cycle(0, 0, 0, 0, 1, 1);
    sine_run(80, 4096.0, 2, 100, 0);        // R7 limit above sums

    // phase 3: long windows, one phase losing its positive half, random acks
    do_reset();
    win_len = 7'd60; thr = 16'(3000 + $urandom_range(0, 4000)); res = 16'd500;
    sine_run(600, 4096.0, 0, 95, 0);
    sine_run(400, 4096.0, 1, 95, 3);
    win_len = 7'd1; thr = 16'd100; res = 16'd0;
    sine_run(100, 4096.0, 0, 95, 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule